// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Masking

This block gathers a set of level-sensitive interrupt request lines and presents one request to a processor core. With the request it gives the winning priority level and a source code. Every source has a programmable priority held in a small register file. The register file is written and read through a plain register port. There are two kinds of source. External sources take a 4-bit level. On-chip module sources take a 5-bit fine setting, which orders them more finely but lands on the same level scale.

The winning request is gated by four things: the core's current interrupt mask, its block bit, a user-mode mask level when the core runs in user mode, and the level itself. A non-maskable interrupt input is edge-detected, and the active edge is selectable. The interrupt is latched until the core acknowledges it. It outranks every maskable source and ignores both mask levels. A configuration bit decides whether it may pass while the block bit is set. When the core acknowledges the presented request, the block returns the accepted level, and the core loads that level into its mask field.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all priority, mask and configuration registers are zero. irqOut, irqLevel, irqCode and imaskUpd are 0, and imaskNew is 0.
- R2: An external source i (0..NUM_EXT-1) has a 4-bit priority register at address i. Its level equals the value, and value 0 disables the source.
- R3: A module source j has a 5-bit fine setting at address NUM_EXT+j. Its level is the setting shifted right by one, so settings 0 and 1 disable it. A higher fine setting wins over a lower one that has the same level.
- R4: The winner is the enabled source with the highest rank. An external source ranks as 2*level+1 and a module source ranks as its fine setting. On equal rank, the lowest source index wins, and external indices come before module indices.
- R5: A maskable source is presented only if its level is strictly greater than cpuImask and cpuBl is 0.
- R6: While cpuUserMode is 1, a maskable source is presented only if its level is also strictly greater than the user mask register at address NUM_EXT+NUM_MOD+1 (bits 3:0).
- R7: The outputs are registered. Values sampled on a clock edge appear after that edge. A request that deasserts or becomes masked is withdrawn at the next edge. When irqOut is 0, irqLevel and irqCode are 0.
- R8: The non-maskable input is sampled each edge. An active edge sets a pending flag at the sampling edge. The active edge is rising when control bit 0 is 1 and falling when it is 0. The control register is at address NUM_EXT+NUM_MOD. A pending request is presented with irqCode = NUM_EXT+NUM_MOD and irqLevel = 15.
- R9: A pending non-maskable request wins over every maskable source and ignores cpuImask and the user mask.
- R10: While cpuBl is 1, a pending non-maskable request is presented only if control bit 1 is 1. Otherwise it stays pending and appears once cpuBl returns to 0.
- R11: When ack is 1 while irqOut is 1, imaskUpd pulses for one cycle after that edge, and imaskNew holds the irqLevel that was acknowledged. If the acknowledged code is the non-maskable one, the pending flag clears and the request is gone from the next output. An ack while irqOut is 0 has no effect.
- R12: All registers read back on regRdata combinationally. The status address NUM_EXT+NUM_MOD+2 reads bit 0 as the last sampled level of the non-maskable input and bit 1 as its pending flag. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | LVL_W+1 | Register write data |
| regRdata | output | LVL_W+1 | Register read data |
| irqReq | input | NUM_EXT+NUM_MOD | Level-sensitive requests, external sources first |
| nmiPin | input | 1 | Non-maskable interrupt input |
| cpuImask | input | LVL_W | Core's current interrupt mask level |
| cpuBl | input | 1 | Core block bit |
| cpuUserMode | input | 1 | Core runs in user mode |
| ack | input | 1 | Core accepts the presented request |
| irqOut | output | 1 | Request to the core |
| irqLevel | output | LVL_W | Level of the presented request |
| irqCode | output | CODE_W | Source index, NUM_EXT+NUM_MOD for the non-maskable input |
| imaskUpd | output | 1 | Pulse: new mask level valid |
| imaskNew | output | LVL_W | Accepted level to load into the core mask |

## Verification
Maskable results take one edge: a request, priority or mask change sampled on edge k shows on irqOut, irqLevel and irqCode after edge k. A non-maskable pin change is seen at the edge that samples it and is presented one edge later. An acknowledge gives imaskUpd and imaskNew after the edge that samples it, and an acknowledged non-maskable request is withdrawn at that same edge. Read data follows the address with no delay. The bench's reference model advances on each rising edge with these delays. Inputs are driven just after the falling edge, and every output is compared at the falling edge, so each check sees a settled value.

// File: rtl/prio_irq_ctrl_pkg.sv
package prio_irq_ctrl_pkg;

  // Configuration bits the control side needs from the register file.
  typedef struct packed {
    logic nmiRise;    // 1: rising edge is active, 0: falling edge
    logic nmiOverBl;  // 1: non-maskable request passes while block bit set
  } ctrlCfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic nmiReq;     // pending and not being cleared this cycle
    logic nmiHeld;    // raw pending flag (status)
    logic nmiSample;  // last sampled pin level (status)
    logic accept;     // core acknowledged the presented request
  } ctlStrobe_t;

endpackage

// File: rtl/prio_irq_ctrl_control.sv
module prio_irq_ctrl_control
  import prio_irq_ctrl_pkg::*;
#(
  parameter int NSRC   = 10,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPin,
  input  logic              ack,
  input  logic              irqOut,
  input  logic [CODE_W-1:0] irqCode,
  input  ctrlCfg_t          cfg,
  output ctlStrobe_t        strobe
);

  logic nmiPrevQ;
  logic nmiPendQ;
  logic edgeHit;
  logic acceptNow;
  logic nmiClear;

  always_comb begin
    if (cfg.nmiRise) edgeHit = nmiPin & ~nmiPrevQ;
    else             edgeHit = ~nmiPin & nmiPrevQ;
    acceptNow = ack & irqOut;
    nmiClear  = acceptNow && (irqCode == CODE_W'(NSRC));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrevQ <= 1'b0;
      nmiPendQ <= 1'b0;
    end else begin
      nmiPrevQ <= nmiPin;
      // a fresh edge wins over a clear in the same cycle
      nmiPendQ <= edgeHit | (nmiPendQ & ~nmiClear);
    end
  end

  always_comb begin
    strobe.nmiReq    = nmiPendQ & ~nmiClear;
    strobe.nmiHeld   = nmiPendQ;
    strobe.nmiSample = nmiPrevQ;
    strobe.accept    = acceptNow;
  end

endmodule

// File: rtl/prio_irq_ctrl_datapath.sv
module prio_irq_ctrl_datapath
  import prio_irq_ctrl_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int NUM_MOD = 6,
  parameter int LVL_W   = 4,
  parameter int ADDR_W  = 4,
  parameter int CODE_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [LVL_W:0]        regWdata,
  output logic [LVL_W:0]        regRdata,
  input  logic [NUM_EXT+NUM_MOD-1:0] irqReq,
  input  logic [LVL_W-1:0]      cpuImask,
  input  logic                  cpuBl,
  input  logic                  cpuUserMode,
  input  ctlStrobe_t            strobe,
  output ctrlCfg_t              cfg,
  output logic [LVL_W-1:0]      userMask,
  output logic                  irqOut,
  output logic [LVL_W-1:0]      irqLevel,
  output logic [CODE_W-1:0]     irqCode,
  output logic                  imaskUpd,
  output logic [LVL_W-1:0]      imaskNew
);

  localparam int NSRC      = NUM_EXT + NUM_MOD;
  localparam int RANK_W    = LVL_W + 1;
  localparam int DATA_W    = LVL_W + 1;
  localparam int ADDR_CTRL = NSRC;
  localparam int ADDR_UMSK = NSRC + 1;
  localparam int ADDR_STAT = NSRC + 2;

  logic [LVL_W-1:0]  extPriQ [NUM_EXT];
  logic [RANK_W-1:0] modPriQ [NUM_MOD];
  ctrlCfg_t          cfgQ;
  logic [LVL_W-1:0]  userMaskQ;

  // ---------------- register file ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EXT; i++) extPriQ[i] <= '0;
      for (int j = 0; j < NUM_MOD; j++) modPriQ[j] <= '0;
      cfgQ      <= '0;
      userMaskQ <= '0;
    end else if (regWe) begin
      for (int i = 0; i < NUM_EXT; i++)
        if (regAddr == ADDR_W'(i)) extPriQ[i] <= regWdata[LVL_W-1:0];
      for (int j = 0; j < NUM_MOD; j++)
        if (regAddr == ADDR_W'(NUM_EXT + j)) modPriQ[j] <= regWdata;
      if (regAddr == ADDR_W'(ADDR_CTRL)) begin
        cfgQ.nmiRise   <= regWdata[0];
        cfgQ.nmiOverBl <= regWdata[1];
      end
      if (regAddr == ADDR_W'(ADDR_UMSK)) userMaskQ <= regWdata[LVL_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_EXT; i++)
      if (regAddr == ADDR_W'(i)) regRdata = DATA_W'(extPriQ[i]);
    for (int j = 0; j < NUM_MOD; j++)
      if (regAddr == ADDR_W'(NUM_EXT + j)) regRdata = modPriQ[j];
    if (regAddr == ADDR_W'(ADDR_CTRL)) regRdata = DATA_W'({cfgQ.nmiOverBl, cfgQ.nmiRise});
    if (regAddr == ADDR_W'(ADDR_UMSK)) regRdata = DATA_W'(userMaskQ);
    if (regAddr == ADDR_W'(ADDR_STAT)) regRdata = DATA_W'({strobe.nmiHeld, strobe.nmiSample});
  end

  assign cfg      = cfgQ;
  assign userMask = userMaskQ;

  // ---------------- per-source rank and eligibility ----------------
  logic [RANK_W-1:0] rank [NSRC];
  logic [NSRC-1:0]   elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [LVL_W-1:0] lvl;
    if (g < NUM_EXT) begin : g_ext
      assign rank[g] = (extPriQ[g] == '0) ? '0 : {extPriQ[g], 1'b1};
    end else begin : g_mod
      assign rank[g] = modPriQ[g - NUM_EXT];
    end
    assign lvl     = rank[g][RANK_W-1:1];
    assign elig[g] = irqReq[g] && (lvl != '0) && (lvl > cpuImask) && !cpuBl &&
                     (!cpuUserMode || (lvl > userMaskQ));
  end

  // ---------------- arbitration ----------------
  logic [RANK_W-1:0] bestRank;
  logic [CODE_W-1:0] bestIdx;
  logic              anyHit;
  logic              nmiGo;
  logic              outNext;
  logic [LVL_W-1:0]  lvlNext;
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    bestRank = '0;
    bestIdx  = '0;
    anyHit   = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!anyHit || (rank[i] > bestRank))) begin
        anyHit   = 1'b1;
        bestRank = rank[i];
        bestIdx  = CODE_W'(i);
      end
    end
  end

  always_comb begin
    nmiGo    = strobe.nmiReq && (!cpuBl || cfgQ.nmiOverBl);
    outNext  = 1'b0;
    lvlNext  = '0;
    codeNext = '0;
    if (nmiGo) begin
      outNext  = 1'b1;
      lvlNext  = '1;
      codeNext = CODE_W'(NSRC);
    end else if (anyHit) begin
      outNext  = 1'b1;
      lvlNext  = bestRank[RANK_W-1:1];
      codeNext = bestIdx;
    end
  end

  // ---------------- output and accept registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut   <= 1'b0;
      irqLevel <= '0;
      irqCode  <= '0;
      imaskUpd <= 1'b0;
      imaskNew <= '0;
    end else begin
      irqOut   <= outNext;
      irqLevel <= lvlNext;
      irqCode  <= codeNext;
      imaskUpd <= strobe.accept;
      if (strobe.accept) imaskNew <= irqLevel;
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_ctrl_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int NUM_MOD = 6,
  parameter int LVL_W   = 4,
  parameter int ADDR_W  = 4,
  localparam int NSRC   = NUM_EXT + NUM_MOD,
  localparam int CODE_W = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LVL_W:0]    regWdata,
  output logic [LVL_W:0]    regRdata,
  input  logic [NSRC-1:0]   irqReq,
  input  logic              nmiPin,
  input  logic [LVL_W-1:0]  cpuImask,
  input  logic              cpuBl,
  input  logic              cpuUserMode,
  input  logic              ack,
  output logic              irqOut,
  output logic [LVL_W-1:0]  irqLevel,
  output logic [CODE_W-1:0] irqCode,
  output logic              imaskUpd,
  output logic [LVL_W-1:0]  imaskNew
);

  ctrlCfg_t         cfg;
  ctlStrobe_t       strobe;
  logic [LVL_W-1:0] userMask;

  prio_irq_ctrl_control #(.NSRC(NSRC), .CODE_W(CODE_W)) u_ctl (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .ack(ack),
    .irqOut(irqOut), .irqCode(irqCode), .cfg(cfg), .strobe(strobe)
  );

  prio_irq_ctrl_datapath #(
    .NUM_EXT(NUM_EXT), .NUM_MOD(NUM_MOD), .LVL_W(LVL_W),
    .ADDR_W(ADDR_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq),
    .cpuImask(cpuImask), .cpuBl(cpuBl), .cpuUserMode(cpuUserMode),
    .strobe(strobe), .cfg(cfg), .userMask(userMask),
    .irqOut(irqOut), .irqLevel(irqLevel), .irqCode(irqCode),
    .imaskUpd(imaskUpd), .imaskNew(imaskNew)
  );

endmodule

// File: rtl/prio_irq_ctrl_checker.sv
module prio_irq_ctrl_checker #(
  parameter int NSRC   = 10,
  parameter int LVL_W  = 4,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              ack,
  input logic              cpuBl,
  input logic              cpuUserMode,
  input logic [LVL_W-1:0]  cpuImask,
  input logic [LVL_W-1:0]  userMask,
  input logic              nmiOverBl,
  input logic              irqOut,
  input logic [LVL_W-1:0]  irqLevel,
  input logic [CODE_W-1:0] irqCode,
  input logic              imaskUpd,
  input logic [LVL_W-1:0]  imaskNew
);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (irqLevel == '0 && irqCode == '0));

  p_code_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqCode <= CODE_W'(NSRC)));

  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && irqCode != CODE_W'(NSRC)) |-> (irqLevel > $past(cpuImask) && !$past(cpuBl)));

  p_user_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && irqCode != CODE_W'(NSRC) && $past(cpuUserMode)) |-> (irqLevel > $past(userMask)));

  p_nmi_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && irqCode == CODE_W'(NSRC) && $past(cpuBl)) |-> $past(nmiOverBl));

  p_accept_level_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqOut) |=> (imaskUpd && imaskNew == $past(irqLevel)));

  p_no_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(ack && irqOut) |=> (!imaskUpd && $stable(imaskNew)));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_checker #(.NSRC(NSRC), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .ack(ack), .cpuBl(cpuBl), .cpuUserMode(cpuUserMode),
  .cpuImask(cpuImask), .userMask(userMask), .nmiOverBl(cfg.nmiOverBl),
  .irqOut(irqOut), .irqLevel(irqLevel), .irqCode(irqCode),
  .imaskUpd(imaskUpd), .imaskNew(imaskNew)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NM = 6;
  localparam int NS = NE + NM;
  localparam int A_CTRL = NS;
  localparam int A_UMSK = NS + 1;
  localparam int A_STAT = NS + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [4:0] regWdata = '0;
  logic [4:0] regRdata;
  logic [NS-1:0] irqReq = '0;
  logic nmiPin = 1'b0;
  logic [3:0] cpuImask = '0;
  logic cpuBl = 1'b0;
  logic cpuUserMode = 1'b0;
  logic ack = 1'b0;
  logic irqOut;
  logic [3:0] irqLevel;
  logic [3:0] irqCode;
  logic imaskUpd;
  logic [3:0] imaskNew;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq),
    .nmiPin(nmiPin), .cpuImask(cpuImask), .cpuBl(cpuBl),
    .cpuUserMode(cpuUserMode), .ack(ack), .irqOut(irqOut),
    .irqLevel(irqLevel), .irqCode(irqCode), .imaskUpd(imaskUpd),
    .imaskNew(imaskNew)
  );

  // ---------------- reference model ----------------
  int mExt[NE];
  int mMod[NM];
  int mRise, mOverBl, mUser, mPrev, mPend;
  int mOut, mLvl, mCode, mUpd, mNew;
  int nOut, nLvl, nCode, best, r, l, edgeHit, clr, nmiEff;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit started = 0;
  string curReq = "R1";

  initial begin
    foreach (mExt[i]) mExt[i] = 0;
    foreach (mMod[i]) mMod[i] = 0;
    {mRise, mOverBl, mUser, mPrev, mPend} = '0;
    {mOut, mLvl, mCode, mUpd, mNew} = '0;
  end

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (!rstN) begin
      foreach (mExt[i]) mExt[i] = 0;
      foreach (mMod[i]) mMod[i] = 0;
      mRise = 0; mOverBl = 0; mUser = 0; mPrev = 0; mPend = 0;
      mOut = 0; mLvl = 0; mCode = 0; mUpd = 0; mNew = 0;
    end else begin
      clr = (ack && mOut != 0 && mCode == NS) ? 1 : 0;
      nmiEff = (mPend != 0 && clr == 0) ? 1 : 0;
      best = -1; nOut = 0; nLvl = 0; nCode = 0;
      for (int i = 0; i < NS; i++) begin
        if (i < NE) r = (mExt[i] != 0) ? 2 * mExt[i] + 1 : 0;
        else        r = mMod[i - NE];
        l = r / 2;
        if (irqReq[i] && l > 0 && l > int'(cpuImask) && !cpuBl &&
            (!cpuUserMode || l > mUser) && r > best) begin
          best = r; nOut = 1; nLvl = l; nCode = i;
        end
      end
      if (nmiEff != 0 && (!cpuBl || mOverBl != 0)) begin
        nOut = 1; nLvl = 15; nCode = NS;
      end
      if (ack && mOut != 0) begin mUpd = 1; mNew = mLvl; end
      else mUpd = 0;
      if (mRise != 0) edgeHit = (nmiPin && mPrev == 0) ? 1 : 0;
      else            edgeHit = (!nmiPin && mPrev != 0) ? 1 : 0;
      mPend = (edgeHit != 0 || (mPend != 0 && clr == 0)) ? 1 : 0;
      mPrev = nmiPin ? 1 : 0;
      if (regWe) begin
        for (int i = 0; i < NE; i++) if (int'(regAddr) == i) mExt[i] = int'(regWdata[3:0]);
        for (int j = 0; j < NM; j++) if (int'(regAddr) == NE + j) mMod[j] = int'(regWdata);
        if (int'(regAddr) == A_CTRL) begin mRise = regWdata[0]; mOverBl = regWdata[1]; end
        if (int'(regAddr) == A_UMSK) mUser = int'(regWdata[3:0]);
      end
      mOut = nOut; mLvl = nLvl; mCode = nCode;
    end
  end

  function automatic int expRead(int a);
    if (a < NE) return mExt[a];
    if (a < NS) return mMod[a - NE];
    if (a == A_CTRL) return mRise + 2 * mOverBl;
    if (a == A_UMSK) return mUser;
    if (a == A_STAT) return mPrev + 2 * mPend;
    return 0;
  endfunction

  // ---------------- comparison on every falling edge ----------------
  always @(negedge clk) begin
    if (started) begin
      int er;
      bit bad;
      bad = 0;
      er = expRead(int'(regAddr));
      vectors++;
      if (int'(irqOut) != mOut) begin bad = 1;
        $display("FAIL %s irqOut actual %0d expected %0d t=%0t", curReq, irqOut, mOut, $time); end
      if (int'(irqLevel) != mLvl) begin bad = 1;
        $display("FAIL %s irqLevel actual %0d expected %0d t=%0t", curReq, irqLevel, mLvl, $time); end
      if (int'(irqCode) != mCode) begin bad = 1;
        $display("FAIL %s irqCode actual %0d expected %0d t=%0t", curReq, irqCode, mCode, $time); end
      if (int'(imaskUpd) != mUpd) begin bad = 1;
        $display("FAIL %s imaskUpd actual %0d expected %0d t=%0t", curReq, imaskUpd, mUpd, $time); end
      if (int'(imaskNew) != mNew) begin bad = 1;
        $display("FAIL %s imaskNew actual %0d expected %0d t=%0t", curReq, imaskNew, mNew, $time); end
      if (int'(regRdata) != er) begin bad = 1;
        $display("FAIL %s regRdata@%0d actual %0d expected %0d t=%0t", curReq, regAddr, regRdata, er, $time); end
      if (bad) miscompares++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    regWe = 1'b1; regAddr = 4'(a); regWdata = 5'(d);
    tick();
    regWe = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog expired before the run completed");
    miscompares++;
    finishRun();
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    tick(3);
    rstN = 1'b1;
    tick(2);

    // R12: register readback and unmapped address
    curReq = "R12";
    for (int a = 0; a < 16; a++) begin regAddr = 4'(a); tick(); end
    wr(0, 5); wr(NE + 1, 21); wr(A_UMSK, 3); wr(A_CTRL, 2);
    for (int a = 0; a < 16; a++) begin regAddr = 4'(a); tick(); end
    wr(A_UMSK, 0); wr(A_CTRL, 0); wr(NE + 1, 0);

    // R2: external level and disable by zero
    curReq = "R2";
    irqReq[0] = 1'b1; tick(2);
    wr(0, 0); tick(2);
    wr(0, 5); tick();

    // R7: level-sensitive withdraw
    curReq = "R7";
    irqReq[0] = 1'b0; tick(2);

    // R4: rank and tie ordering
    curReq = "R4";
    wr(1, 5); irqReq[1:0] = 2'b11; tick(2);
    wr(2, 9); irqReq[2] = 1'b1; tick(2);
    wr(NE + 0, 19); irqReq[NE] = 1'b1; tick(2);
    wr(NE + 1, 18); irqReq[NE+1] = 1'b1; tick(2);

    // R3: fine settings among modules
    curReq = "R3";
    irqReq[2:0] = '0;
    wr(NE + 1, 20); tick(2);
    wr(NE + 0, 1); wr(NE + 1, 1); tick(2);
    wr(NE + 2, 3); irqReq[NE+2] = 1'b1; tick(2);
    irqReq = '0; tick();

    // R5: mask level and block bit
    curReq = "R5";
    wr(2, 9); irqReq[2] = 1'b1;
    cpuImask = 4'd9; tick(2);
    cpuImask = 4'd8; tick(2);
    cpuBl = 1'b1; tick(2);
    cpuBl = 1'b0; cpuImask = 4'd0; tick();

    // R6: user-mode mask
    curReq = "R6";
    wr(A_UMSK, 9); cpuUserMode = 1'b1; tick(2);
    wr(A_UMSK, 8); tick(2);
    wr(A_UMSK, 9); cpuUserMode = 1'b0; tick(2);
    wr(A_UMSK, 0); irqReq = '0; tick();

    // R8: falling edge by default, then rising
    curReq = "R8";
    nmiPin = 1'b1; tick(3);
    regAddr = 4'(A_STAT); nmiPin = 1'b0; tick(3);
    curReq = "R11";
    ack = 1'b1; tick(); ack = 1'b0; tick(2);
    curReq = "R8";
    wr(A_CTRL, 1); regAddr = 4'(A_STAT);
    nmiPin = 1'b1; tick(3);

    // R9: wins over maskable regardless of masks
    curReq = "R9";
    irqReq[2] = 1'b1; cpuImask = 4'd15; cpuUserMode = 1'b1; tick(2);
    cpuImask = 4'd0; cpuUserMode = 1'b0; tick();
    curReq = "R11";
    ack = 1'b1; tick(); ack = 1'b0; tick(2);
    ack = 1'b1; tick(); ack = 1'b0; tick(2);
    irqReq = '0; tick(2);
    ack = 1'b1; tick(); ack = 1'b0; tick(2);

    // R10: block bit holds the non-maskable request unless enabled
    curReq = "R10";
    cpuBl = 1'b1; regAddr = 4'(A_STAT);
    nmiPin = 1'b0; tick(); nmiPin = 1'b1; tick(4);
    cpuBl = 1'b0; tick(2);
    ack = 1'b1; tick(); ack = 1'b0;
    wr(A_CTRL, 3); cpuBl = 1'b1;
    nmiPin = 1'b0; tick(); nmiPin = 1'b1; tick(3);
    ack = 1'b1; tick(); ack = 1'b0; tick(2);
    cpuBl = 1'b0; tick();

    // mixed stimulus against the model
    curReq = "R4";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 19));
      irqReq      = NS'($urandom);
      cpuImask    = 4'($urandom_range(0, 15));
      cpuBl       = ($urandom_range(0, 5) == 0);
      cpuUserMode = ($urandom_range(0, 3) == 0);
      ack         = ($urandom_range(0, 3) == 0);
      nmiPin      = ($urandom_range(0, 7) == 0) ? ~nmiPin : nmiPin;
      regAddr     = 4'($urandom_range(0, 15));
      regWdata    = 5'($urandom);
      regWe       = (sel < 3);
      tick();
    end
    regWe = 1'b0; ack = 1'b0;
    tick(2);
    finishRun();
  end

endmodule